// File: doc/BRIEF.md
# ADC Scan Sequencer with Split Result Queues

This block drives a 10-bit successive-approximation converter across 16 analog inputs. Software starts a scan over a programmed channel window. The scan steps through the window one channel at a time. In one-shot mode it stops after the last channel. In continuous mode it returns to the first channel until software stops it. An external trigger requests a single conversion of a separately programmed channel. A trigger that arrives while a software scan is running is served between two software channels and goes ahead of the next one.

Each finished conversion becomes a queue entry that holds the 4-bit channel number and the 10-bit result. Results of software-started conversions go to one 6-entry queue. Triggered results go to a second 6-entry queue of the same shape. Each queue has its own read strobe, empty and full flags, and a sticky overrun flag. The converter sits outside the block. The block hands it a start pulse and a channel number, and it answers with a done strobe and the result.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset both queues are empty and not full, both overrun flags are low, `busy` is low and `conv_start` is low.
- R2: A one-shot scan converts channels from `cfg_first_ch` upward to `cfg_last_ch`, each exactly once. Channel 15 is followed by channel 0, so a window with first greater than last wraps. After the last channel `busy` drops.
- R3: In continuous mode the scan goes back to `cfg_first_ch` after `cfg_last_ch` until `sw_stop` is pulsed. A conversion already running when stop arrives still completes and is stored, and no further software conversion is launched.
- R4: A software-started result is written to the software queue and a triggered result to the trigger queue. An entry is `{channel[13:10], result[9:0]}`.
- R5: A `hw_trig` pulse causes one conversion of `cfg_hw_ch`. If a software conversion is running, the triggered conversion is launched once that conversion ends, before the next software channel.
- R6: At most one conversion is in flight. `conv_start` is a single-cycle pulse, and the next pulse comes only after `conv_done`.
- R7: Each queue returns entries in arrival order, with the oldest entry visible on its read data while not empty. It holds up to 6 unread entries, and `*_full` is high with 6 stored. A read strobe on an empty queue changes nothing.
- R8: A result that arrives when its queue is full is discarded and that queue's overrun flag sets. The flag stays set until reset, including after the queue is drained. The other queue is not affected.
- R9: `sw_start` has no effect while a software scan is active or a software conversion is still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software scan start pulse |
| sw_stop | input | 1 | Ends an active software scan |
| hw_trig | input | 1 | Trigger pulse requesting one conversion of `cfg_hw_ch` |
| cfg_first_ch | input | 4 | First channel of the scan window |
| cfg_last_ch | input | 4 | Last channel of the scan window |
| cfg_hw_ch | input | 4 | Channel converted on a trigger |
| cfg_continuous | input | 1 | 1: repeat the window, 0: one pass |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | 4 | Channel for the conversion being started |
| conv_done | input | 1 | Converter finished strobe |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| busy | output | 1 | Scan active, trigger pending or conversion running |
| sw_rd | input | 1 | Pop strobe, software queue |
| sw_rdata | output | 14 | Oldest software entry |
| sw_empty | output | 1 | Software queue empty |
| sw_full | output | 1 | Software queue full |
| sw_ovr | output | 1 | Sticky software overrun |
| hw_rd | input | 1 | Pop strobe, trigger queue |
| hw_rdata | output | 14 | Oldest trigger entry |
| hw_empty | output | 1 | Trigger queue empty |
| hw_full | output | 1 | Trigger queue full |
| hw_ovr | output | 1 | Sticky trigger overrun |

## Verification
The embedded properties check the following on every cycle: that start pulses last one cycle, that a start never overlaps a running conversion, that a waiting trigger wins over the next software channel, that queue occupancy stays within bounds, that overrun is sticky, and that a pop on an empty queue is harmless. The channel order of a scan and the wrap from 15 to 0 can only be shown by the bench's scenarios, which sweep many first/last windows. The same holds for continuous repetition and the stop point, for the result contents routed to each queue, for the discarded results on overrun, and for the ignored restart.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic { SRC_SW = 1'b0, SRC_HW = 1'b1 } conv_src_e;
  typedef enum logic { ST_IDLE = 1'b0, ST_CONV = 1'b1 } seq_state_e;
endpackage

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         ovr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_q];
  assign ovr     = ovr_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovr_d = ovr_q | (push & full);
    if (push_ok) wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && ovr));
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 10,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              hw_trig,
  input  logic [CH_W-1:0]   cfg_first_ch,
  input  logic [CH_W-1:0]   cfg_last_ch,
  input  logic [CH_W-1:0]   cfg_hw_ch,
  input  logic              cfg_continuous,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  output logic              sw_push,
  output logic              hw_push,
  output logic [CH_W-1:0]   res_ch,
  output logic              busy
);
  localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

  seq_state_e      state_q, state_d;
  conv_src_e       src_q, src_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic [CH_W-1:0] nxt_q, nxt_d;
  logic            act_q, act_d;
  logic            pend_q, pend_d;
  logic            launch_hw, launch_sw, sw_busy, start_ok, done_sw, at_last;

  assign launch_hw  = (state_q == ST_IDLE) && pend_q;
  assign launch_sw  = (state_q == ST_IDLE) && !pend_q && act_q;
  assign conv_start = launch_hw || launch_sw;
  assign conv_ch    = launch_hw ? cfg_hw_ch : nxt_q;
  assign sw_busy    = act_q || ((state_q == ST_CONV) && (src_q == SRC_SW));
  assign start_ok   = sw_start && !sw_busy;
  assign done_sw    = (state_q == ST_CONV) && conv_done && (src_q == SRC_SW);
  assign at_last    = (nxt_q == cfg_last_ch);
  assign sw_push    = done_sw;
  assign hw_push    = (state_q == ST_CONV) && conv_done && (src_q == SRC_HW);
  assign res_ch     = cur_q;
  assign busy       = sw_busy || pend_q || (state_q == ST_CONV);

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    cur_d   = cur_q;
    nxt_d   = nxt_q;
    act_d   = act_q && !sw_stop && !(done_sw && at_last && !cfg_continuous);
    pend_d  = hw_trig || (pend_q && !launch_hw);
    if (conv_start) begin
      state_d = ST_CONV;
      src_d   = launch_hw ? SRC_HW : SRC_SW;
      cur_d   = conv_ch;
    end else if ((state_q == ST_CONV) && conv_done) begin
      state_d = ST_IDLE;
    end
    if (start_ok) begin
      act_d = 1'b1;
      nxt_d = cfg_first_ch;
    end else if (done_sw && act_q) begin
      if (at_last)              nxt_d = cfg_first_ch;
      else if (nxt_q == TOP_CH) nxt_d = '0;
      else                      nxt_d = nxt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_SW;
      cur_q   <= '0;
      nxt_q   <= '0;
      act_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
    end
  end

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && !conv_done) |=> !conv_start);
  p_hw_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && pend_q) |-> (conv_ch == cfg_hw_ch));
  p_one_queue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_push && hw_push));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH     = 16,
  parameter int RES_W      = 10,
  parameter int FIFO_DEPTH = 6,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int ENT_W     = CH_W + RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             hw_trig,
  input  logic [CH_W-1:0]  cfg_first_ch,
  input  logic [CH_W-1:0]  cfg_last_ch,
  input  logic [CH_W-1:0]  cfg_hw_ch,
  input  logic             cfg_continuous,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             busy,
  input  logic             sw_rd,
  output logic [ENT_W-1:0] sw_rdata,
  output logic             sw_empty,
  output logic             sw_full,
  output logic             sw_ovr,
  input  logic             hw_rd,
  output logic [ENT_W-1:0] hw_rdata,
  output logic             hw_empty,
  output logic             hw_full,
  output logic             hw_ovr
);
  localparam int NQ = 2;

  logic             sw_push, hw_push;
  logic [CH_W-1:0]  res_ch;
  logic [ENT_W-1:0] entry;
  logic [NQ-1:0]    q_push, q_pop, q_empty, q_full, q_ovr;
  logic [ENT_W-1:0] q_rdata [NQ];

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sw_start(sw_start), .sw_stop(sw_stop), .hw_trig(hw_trig),
    .cfg_first_ch(cfg_first_ch), .cfg_last_ch(cfg_last_ch),
    .cfg_hw_ch(cfg_hw_ch), .cfg_continuous(cfg_continuous),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .sw_push(sw_push), .hw_push(hw_push), .res_ch(res_ch), .busy(busy)
  );

  assign entry  = {res_ch, conv_result};
  assign q_push = {hw_push, sw_push};
  assign q_pop  = {hw_rd, sw_rd};

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    adc_result_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(q_push[g]), .wdata(entry), .pop(q_pop[g]),
      .rdata(q_rdata[g]), .empty(q_empty[g]), .full(q_full[g]), .ovr(q_ovr[g])
    );
  end

  assign sw_rdata = q_rdata[0];
  assign sw_empty = q_empty[0];
  assign sw_full  = q_full[0];
  assign sw_ovr   = q_ovr[0];
  assign hw_rdata = q_rdata[1];
  assign hw_empty = q_empty[1];
  assign hw_full  = q_full[1];
  assign hw_ovr   = q_ovr[1];
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_CYC   = 5;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n;
  logic       sw_start, sw_stop, hw_trig, cfg_continuous;
  logic [3:0] cfg_first_ch, cfg_last_ch, cfg_hw_ch;
  logic       conv_start, conv_done, busy;
  logic [3:0] conv_ch;
  logic [9:0] conv_result;
  logic       sw_rd, sw_empty, sw_full, sw_ovr;
  logic       hw_rd, hw_empty, hw_full, hw_ovr;
  logic [13:0] sw_rdata, hw_rdata;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_stop(sw_stop),
    .hw_trig(hw_trig), .cfg_first_ch(cfg_first_ch), .cfg_last_ch(cfg_last_ch),
    .cfg_hw_ch(cfg_hw_ch), .cfg_continuous(cfg_continuous),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_result(conv_result), .busy(busy),
    .sw_rd(sw_rd), .sw_rdata(sw_rdata), .sw_empty(sw_empty), .sw_full(sw_full), .sw_ovr(sw_ovr),
    .hw_rd(hw_rd), .hw_rdata(hw_rdata), .hw_empty(hw_empty), .hw_full(hw_full), .hw_ovr(hw_ovr)
  );

  int n_chk = 0, n_fail = 0;
  bit auto_rd = 1'b1, poke = 1'b0, done_flag = 1'b0;
  int sw_n = 0, hw_n = 0, n_launch = 0, cyc = 0;
  logic [13:0] sw_got [0:255];
  logic [13:0] hw_got [0:255];
  logic [3:0]  launched [0:255];

  function automatic logic [9:0] model_res(input logic [3:0] ch);
    return 10'((int'(ch) * 61 + 3) & 10'h3FF);
  endfunction
  function automatic logic [13:0] model_ent(input logic [3:0] ch);
    return {ch, model_res(ch)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  // behavioural converter
  initial begin
    int cnt = 0;
    logic [3:0] lch = '0;
    conv_done = 1'b0;
    conv_result = '0;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (cnt == 1) begin
        conv_done = 1'b1;
        conv_result = model_res(lch);
      end
      if (cnt > 0) cnt--;
      if (rst_n && conv_start) begin
        cnt = CONV_CYC;
        lch = conv_ch;
        launched[n_launch[7:0]] = conv_ch;
        n_launch++;
      end
    end
  end

  // queue readers
  initial begin
    sw_rd = 1'b0;
    hw_rd = 1'b0;
    forever begin
      @(negedge clk);
      sw_rd = (auto_rd && !sw_empty) || poke;
      hw_rd = auto_rd && !hw_empty;
      if (rst_n && auto_rd && !sw_empty) begin sw_got[sw_n[7:0]] = sw_rdata; sw_n++; end
      if (rst_n && auto_rd && !hw_empty) begin hw_got[hw_n[7:0]] = hw_rdata; hw_n++; end
    end
  end

  task automatic pulse_start();
    sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy || (auto_rd && (!sw_empty || !hw_empty))) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_logs();
    sw_n = 0; hw_n = 0; n_launch = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    sw_start = 1'b0; sw_stop = 1'b0; hw_trig = 1'b0;
    cfg_first_ch = '0; cfg_last_ch = '0; cfg_hw_ch = '0; cfg_continuous = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(sw_empty && hw_empty, "R1 empty", {sw_empty, hw_empty}, 3);
    chk(!sw_full && !hw_full, "R1 full", {sw_full, hw_full}, 0);
    chk(!sw_ovr && !hw_ovr, "R1 ovr", {sw_ovr, hw_ovr}, 0);
    chk(!busy && !conv_start, "R1 idle", {busy, conv_start}, 0);

    // R2/R4 sweep of one-shot windows, including wrap past channel 15
    for (int f = 0; f < 16; f += 3) begin
      for (int k = 0; k < 3; k++) begin
        int span, nexp;
        span = (k == 0) ? 0 : (k == 1) ? 4 : 15;
        nexp = span + 1;
        clear_logs();
        cfg_first_ch = 4'(f);
        cfg_last_ch  = 4'(f + span);
        pulse_start();
        wait_idle();
        chk(sw_n == nexp, "R2 count", sw_n, nexp);
        chk(hw_n == 0, "R4 no trigger entries", hw_n, 0);
        for (int i = 0; i < nexp; i++) begin
          logic [13:0] e;
          e = model_ent(4'(f + i));
          chk(sw_got[i] == e, "R2/R4 entry", int'(sw_got[i]), int'(e));
        end
      end
    end
    chk(!busy, "R2 busy drops", busy, 0);

    // R3 continuous mode and stop
    clear_logs();
    cfg_first_ch = 4'd2; cfg_last_ch = 4'd4; cfg_continuous = 1'b1;
    pulse_start();
    while (sw_n < 8) @(negedge clk);
    sw_stop = 1'b1; @(negedge clk); sw_stop = 1'b0;
    wait_idle();
    cfg_continuous = 1'b0;
    chk(sw_n >= 8 && sw_n <= 9, "R3 stop point", sw_n, 9);
    for (int i = 0; i < sw_n; i++) begin
      logic [13:0] e;
      e = model_ent(4'(2 + (i % 3)));
      chk(sw_got[i] == e, "R3 repeat", int'(sw_got[i]), int'(e));
    end
    chk(n_launch == sw_n, "R3 no launch after stop", n_launch, sw_n);

    // R5 trigger while idle
    clear_logs();
    cfg_hw_ch = 4'd7;
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    wait_idle();
    chk(hw_n == 1 && hw_got[0] == model_ent(4'd7), "R5 idle trigger", int'(hw_got[0]), int'(model_ent(4'd7)));
    chk(sw_n == 0, "R4 trigger result not in sw queue", sw_n, 0);

    // R5 trigger during a scan takes the next slot
    clear_logs();
    cfg_first_ch = 4'd0; cfg_last_ch = 4'd5; cfg_hw_ch = 4'd12;
    pulse_start();
    while (n_launch < 2) @(negedge clk);
    hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
    wait_idle();
    chk(n_launch == 7, "R5 launch count", n_launch, 7);
    chk(launched[2] == 4'd12, "R5 priority slot", launched[2], 12);
    chk(launched[3] == 4'd2, "R5 scan resumes", launched[3], 2);
    chk(hw_n == 1 && hw_got[0] == model_ent(4'd12), "R5 trigger entry", int'(hw_got[0]), int'(model_ent(4'd12)));
    chk(sw_n == 6, "R5 scan entries", sw_n, 6);

    // R9 restart ignored during scan
    clear_logs();
    cfg_first_ch = 4'd8; cfg_last_ch = 4'd11;
    pulse_start();
    while (n_launch < 3) @(negedge clk);
    pulse_start();
    wait_idle();
    chk(sw_n == 4, "R9 count", sw_n, 4);
    for (int i = 0; i < 4; i++)
      chk(sw_got[i] == model_ent(4'(8 + i)), "R9 order", int'(sw_got[i]), int'(model_ent(4'(8 + i))));

    // R7 pop on empty queue, then R7/R8 overrun
    clear_logs();
    auto_rd = 1'b0;
    @(negedge clk);
    poke = 1'b1; @(negedge clk); poke = 1'b0; @(negedge clk);
    chk(sw_empty && !sw_full, "R7 empty pop harmless", {sw_empty, sw_full}, 2);
    cfg_first_ch = 4'd0; cfg_last_ch = 4'd7;
    pulse_start();
    wait_idle();
    chk(sw_full, "R7 full at six", sw_full, 1);
    chk(sw_ovr, "R8 overrun set", sw_ovr, 1);
    chk(!hw_ovr && hw_empty, "R8 other queue untouched", {hw_ovr, hw_empty}, 1);
    chk(sw_rdata == model_ent(4'd0), "R7 oldest visible", int'(sw_rdata), int'(model_ent(4'd0)));
    auto_rd = 1'b1;
    wait_idle();
    chk(sw_n == 6, "R8 dropped results", sw_n, 6);
    for (int i = 0; i < 6; i++)
      chk(sw_got[i] == model_ent(4'(i)), "R7 order", int'(sw_got[i]), int'(model_ent(4'(i))));
    chk(sw_empty && sw_ovr, "R8 overrun sticky", {sw_empty, sw_ovr}, 3);

    finish_run();
  end
endmodule